// File: doc/BRIEF.md
# Multi-Mode Educational Clock Generator

This block produces the clock enable for a small teaching CPU. It is driven by a fast free-running system clock. The rest of the machine advances only on cycles where `cpu_ce` is high. An operator can choose one of three ways to run the machine:

- **Single-step:** a pushbutton advances the machine one step per press.
- **Slow:** the machine runs at a rate from 1 to 15 Hz, chosen by a 4-bit value.
- **Turbo:** the machine runs at full speed, 1 MHz by default.

The CPU's halt request freezes the enable until the next reset. An LED output toggles on every enable, so students can see each machine step.

Internally the block has four parts:

- A two-stage synchroniser with a counting debouncer and a rising-edge detector for the step button.
- A rate table computed at elaboration from `SYS_CLK_HZ`.
- A reloadable down-counting divider.
- A control state machine with the states `ST_STEP`, `ST_SLOW`, `ST_TURBO` and `ST_HALTED`.

State transitions:

- **Mode transitions:** between any two of `ST_STEP`, `ST_SLOW` and `ST_TURBO`, following `mode_sel`.
- **Halt transition:** from any of those three states into `ST_HALTED` when `halt_req` is sampled high.
- **Halted hold:** `ST_HALTED` never leaves its own state. Only `rst_n` returns the machine to `ST_STEP`.

Every mode transition restarts the divider with the period of the new mode.

Top module: `edu_clock_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycles after it rises with mode code 0 and no button press, `cpu_ce` and `led_clk` are both 0.
- R2: `mode_sel` selects the mode as follows: code 0 and code 3 select single-step, code 1 selects slow, code 2 selects turbo.
- R3: In single-step mode, the button is accepted once it has read the same new level for `DEB_CYCLES` consecutive synchronised samples.
    - An accepted rising level gives exactly one `cpu_ce` pulse, `DEB_CYCLES`+3 cycles after the first edge at which the pin reads high.
    - Bounces or high levels shorter than `DEB_CYCLES`, holding the button and releasing it give no pulse.
- R4: In slow mode with rate r (1..15), consecutive `cpu_ce` pulses are exactly floor(`SYS_CLK_HZ`/r) cycles apart.
- R5: In slow mode, rate 0 behaves exactly like rate 1.
- R6: In turbo mode, consecutive `cpu_ce` pulses are exactly floor(`SYS_CLK_HZ`/`TURBO_HZ`) cycles apart.
- R7: On a change into slow or turbo mode, the divider restarts. The first pulse comes P+1 cycles after the edge that first samples the new mode, where P is the new period. No pulse is given in between.
- R8: From the edge that samples `halt_req` high, `cpu_ce` stays 0 until reset, whatever happens to the mode, the rate and the button. A reset returns the block to normal operation.
- R9: Button presses have no effect in slow or turbo mode. Divider ticks have no effect in single-step mode.
- R10: `cpu_ce` is never high on two consecutive cycles. In slow or turbo mode it never comes sooner than the shortest period the block supports.
- R11: `led_clk` changes value on exactly those edges at which `cpu_ce` becomes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset; also clears the halt state |
| mode_sel | input | 2 | 0/3 single-step, 1 slow, 2 turbo |
| rate_sel | input | RATE_W | Slow-mode rate in Hz (0 treated as 1) |
| step_btn | input | 1 | Raw, asynchronous step pushbutton |
| halt_req | input | 1 | Halt request from the control unit |
| cpu_ce | output | 1 | One-cycle clock enable for the CPU |
| led_clk | output | 1 | Visible clock state, toggles on each enable |

## Verification
Each result has a fixed due cycle, counted from the falling edge where the bench drives the stimulus:

- **Step press:** the enable is due `DEB_CYCLES`+3 rising edges later. The edges are spent in two synchroniser flops, the debounce count, the accept flop and the enable flop.
- **Mode change:** the first enable is due P+2 edges later. One edge samples the mode and restarts the divider, P edges count it down, and one more registers the enable.
- **Halt:** no enable is due from the first sampling edge onward.

The bench timestamps each enable with a rising-edge counter and reads it at falling edges. It compares the exact timestamp of the first pulse against the due cycle, and it compares the differences between later pulses against the period. Windows that must stay quiet are counted over a span longer than any due cycle.

// File: rtl/edu_clk_pkg.sv
package edu_clk_pkg;

    // Mode select encodings seen on the mode_sel port.
    typedef enum logic [1:0] {
        MODE_STEP     = 2'd0,
        MODE_SLOW     = 2'd1,
        MODE_TURBO    = 2'd2,
        MODE_STEP_ALT = 2'd3
    } mode_e;

    // Control states of the enable generator.
    typedef enum logic [1:0] {
        ST_STEP,
        ST_SLOW,
        ST_TURBO,
        ST_HALTED
    } state_e;

    // Running state requested by a mode code.
    function automatic state_e mode_to_state(input logic [1:0] code);
        state_e s;
        unique case (mode_e'(code))
            MODE_STEP:     s = ST_STEP;
            MODE_SLOW:     s = ST_SLOW;
            MODE_TURBO:    s = ST_TURBO;
            MODE_STEP_ALT: s = ST_STEP;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/edu_clk_debounce.sv
module edu_clk_debounce #(
    parameter int DEB_CYCLES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press
);
    localparam int CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   btn_s;
    logic                   level_q;
    logic [CW-1:0]          cnt_q;
    logic                   differs;
    logic                   accept;

    assign btn_s   = sync_q[SYNC_STAGES-1];
    assign differs = (btn_s != level_q);
    assign accept  = differs && (cnt_q == LAST);

    // Synchroniser chain for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], btn_raw};
    end

    // Stability counter: a new level must persist for DEB_CYCLES samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!differs) begin
            cnt_q   <= '0;
        end else if (accept) begin
            level_q <= btn_s;
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Rising-edge pulse of the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) press <= 1'b0;
        else        press <= accept && btn_s;
    end

endmodule

// File: rtl/edu_clk_rate_table.sv
module edu_clk_rate_table #(
    parameter int SYS_CLK_HZ = 50_000_000,
    parameter int TURBO_HZ   = 1_000_000,
    parameter int RATE_W     = 4,
    parameter int CNT_W      = 26
) (
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              sel_turbo,
    output logic [CNT_W-1:0]  period
);
    localparam int NUM_RATES = 1 << RATE_W;
    localparam logic [CNT_W-1:0] TURBO_P = CNT_W'(SYS_CLK_HZ / TURBO_HZ);

    logic [CNT_W-1:0] slow_tbl [NUM_RATES];

    // One constant per rate code; code 0 takes the 1 Hz period.
    for (genvar i = 0; i < NUM_RATES; i++) begin : g_rate
        localparam int DIV = (i == 0) ? 1 : i;
        assign slow_tbl[i] = CNT_W'(SYS_CLK_HZ / DIV);
    end

    assign period = sel_turbo ? TURBO_P : slow_tbl[rate_sel];

endmodule

// File: rtl/edu_clk_divider.sv
module edu_clk_divider #(
    parameter int CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    // Down counter: a tick every 'period' cycles, first one 'period'
    // cycles after a restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (restart) begin
            cnt_q <= period - 1'b1;
            tick  <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q <= period - 1'b1;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
            tick  <= 1'b0;
        end
    end

endmodule

// File: rtl/edu_clk_ctrl.sv
module edu_clk_ctrl
    import edu_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       halt_req,
    input  logic       press,
    input  logic       tick,
    output logic       restart,
    output logic       sel_turbo,
    output logic       cpu_ce,
    output logic       led_clk
);
    state_e state_q;
    state_e state_d;
    logic   ce_d;

    // Next state: halted is absorbing; otherwise follow the mode code.
    always_comb begin
        unique case (state_q)
            ST_HALTED: state_d = ST_HALTED;
            ST_STEP,
            ST_SLOW,
            ST_TURBO:  state_d = halt_req ? ST_HALTED : mode_to_state(mode_sel);
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STEP;
        else        state_q <= state_d;
    end

    assign restart   = (state_d != state_q);
    assign sel_turbo = (state_d == ST_TURBO);

    // Enable source chosen by the state; suppressed on any transition.
    always_comb begin
        ce_d = 1'b0;
        if (state_d == state_q) begin
            unique case (state_q)
                ST_STEP:   ce_d = press;
                ST_SLOW:   ce_d = tick;
                ST_TURBO:  ce_d = tick;
                ST_HALTED: ce_d = 1'b0;
            endcase
        end
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_ce  <= 1'b0;
            led_clk <= 1'b0;
        end else begin
            cpu_ce  <= ce_d;
            led_clk <= led_clk ^ ce_d;
        end
    end

endmodule

// File: rtl/edu_clock_gen.sv
module edu_clock_gen #(
    parameter int SYS_CLK_HZ = 50_000_000,
    parameter int TURBO_HZ   = 1_000_000,
    parameter int RATE_W     = 4,
    parameter int DEB_CYCLES = 500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              step_btn,
    input  logic              halt_req,
    output logic              cpu_ce,
    output logic              led_clk
);
    localparam int CNT_W = $clog2(SYS_CLK_HZ + 1);

    logic             press;
    logic             tick;
    logic             restart;
    logic             sel_turbo;
    logic [CNT_W-1:0] period;

    edu_clk_debounce #(
        .DEB_CYCLES (DEB_CYCLES),
        .SYNC_STAGES(2)
    ) u_debounce (
        .clk    (clk),
        .rst_n  (rst_n),
        .btn_raw(step_btn),
        .press  (press)
    );

    edu_clk_rate_table #(
        .SYS_CLK_HZ(SYS_CLK_HZ),
        .TURBO_HZ  (TURBO_HZ),
        .RATE_W    (RATE_W),
        .CNT_W     (CNT_W)
    ) u_rate_table (
        .rate_sel (rate_sel),
        .sel_turbo(sel_turbo),
        .period   (period)
    );

    edu_clk_divider #(
        .CNT_W(CNT_W)
    ) u_divider (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .period (period),
        .tick   (tick)
    );

    edu_clk_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .halt_req (halt_req),
        .press    (press),
        .tick     (tick),
        .restart  (restart),
        .sel_turbo(sel_turbo),
        .cpu_ce   (cpu_ce),
        .led_clk  (led_clk)
    );

endmodule

// File: rtl/edu_clock_gen_checker.sv
module edu_clock_gen_checker #(
    parameter int SYS_CLK_HZ = 50_000_000,
    parameter int TURBO_HZ   = 1_000_000,
    parameter int RATE_W     = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       halt_req,
    input logic       cpu_ce,
    input logic       led_clk
);
    localparam int SLOW_MIN = SYS_CLK_HZ / ((1 << RATE_W) - 1);
    localparam int TURBO_P  = SYS_CLK_HZ / TURBO_HZ;
    localparam int MIN_P    = (SLOW_MIN < TURBO_P) ? SLOW_MIN : TURBO_P;

    logic halt_seen;
    logic has_prev;
    int   gap_q;
    logic timed_mode;

    assign timed_mode = (mode_sel == 2'd1) || (mode_sel == 2'd2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_seen <= 1'b0;
            has_prev  <= 1'b0;
            gap_q     <= 0;
        end else begin
            halt_seen <= halt_seen | halt_req;
            if (cpu_ce) begin
                has_prev <= 1'b1;
                gap_q    <= 0;
            end else if (gap_q < MIN_P) begin
                gap_q    <= gap_q + 1;
            end
        end
    end

    // R10: enable is a single-cycle pulse
    a_r10_ce_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ce |=> !cpu_ce);

    // R10: in timed modes pulses never come closer than the shortest period
    a_r10_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && has_prev && timed_mode) |-> (gap_q >= MIN_P - 1));

    // R8: no enable on the edge after a halt request
    a_r8_halt_next: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> !cpu_ce);

    // R8: halt persists until reset
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt_seen |-> !cpu_ce);

    // R11: LED toggles exactly with the enable
    a_r11_led_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (led_clk != $past(led_clk)) == cpu_ce);

endmodule

bind edu_clock_gen edu_clock_gen_checker #(
    .SYS_CLK_HZ(SYS_CLK_HZ),
    .TURBO_HZ  (TURBO_HZ),
    .RATE_W    (RATE_W)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_sel(mode_sel),
    .halt_req(halt_req),
    .cpu_ce  (cpu_ce),
    .led_clk (led_clk)
);

// File: tb/edu_clock_gen_bench.sv
module edu_clock_gen_bench;
    localparam int SYS      = 60;
    localparam int TURBO    = 10;
    localparam int DEB      = 4;
    localparam int STEP_LAT = DEB + 3;
    localparam int TURBO_P  = SYS / TURBO;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [3:0] rate = 4'd0;
    logic       btn = 1'b0;
    logic       halt = 1'b0;
    logic       ce;
    logic       led;

    edu_clock_gen #(
        .SYS_CLK_HZ(SYS),
        .TURBO_HZ  (TURBO),
        .RATE_W    (4),
        .DEB_CYCLES(DEB)
    ) u_edu_clock_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_sel(mode),
        .rate_sel(rate),
        .step_btn(btn),
        .halt_req(halt),
        .cpu_ce  (ce),
        .led_clk (led)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Port monitor for R10 / R11.
    int   led_bad  = 0;
    int   wide_bad = 0;
    logic prev_ce  = 1'b0;
    logic prev_led = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if ((led != prev_led) != ce) led_bad++;
            if (ce && prev_ce) wide_bad++;
            prev_ce  = ce;
            prev_led = led;
        end else begin
            prev_ce  = 1'b0;
            prev_led = 1'b0;
        end
    end

    task automatic wait_pulse(input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (ce) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic count_pulses(input int k, output int c);
        c = 0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (ce) c++;
        end
    endtask

    task automatic t_reset();
        int c;
        repeat (3) @(negedge clk);
        chk(ce == 1'b0, "R1", "ce in reset", int'(ce), 0);
        chk(led == 1'b0, "R1", "led in reset", int'(led), 0);
        rst_n = 1'b1;
        count_pulses(10, c);
        chk(c == 0, "R1", "pulses after reset", c, 0);
        chk(led == 1'b0, "R1", "led after reset", int'(led), 0);
    endtask

    task automatic t_step(input logic [1:0] m, input string tag);
        int n, at, c;
        mode = m;
        repeat (3) @(negedge clk);
        btn = 1'b1;
        n = cyc;
        wait_pulse(40, at);
        chk(at == n + STEP_LAT, tag, "step pulse cycle", at - n, STEP_LAT);
        count_pulses(30, c);
        chk(c == 0, tag, "pulses while held", c, 0);
        btn = 1'b0;
        count_pulses(20, c);
        chk(c == 0, tag, "pulses on release", c, 0);
    endtask

    task automatic t_glitch();
        int c;
        mode = 2'd0;
        @(negedge clk);
        btn = 1'b1;
        repeat (DEB - 1) @(negedge clk);
        btn = 1'b0;
        count_pulses(30, c);
        chk(c == 0, "R3", "short press pulses", c, 0);
    endtask

    task automatic t_bounce();
        int n, at, c;
        mode = 2'd0;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            btn = ~btn;
            @(negedge clk);
        end
        btn = 1'b0;
        @(negedge clk);
        btn = 1'b1;
        n = cyc;
        wait_pulse(40, at);
        chk(at == n + STEP_LAT, "R3", "bounced press cycle", at - n, STEP_LAT);
        count_pulses(20, c);
        chk(c == 0, "R3", "extra pulses after bounce", c, 0);
        for (int i = 0; i < 4; i++) begin
            btn = ~btn;
            @(negedge clk);
        end
        btn = 1'b0;
        count_pulses(30, c);
        chk(c == 0, "R3", "bounced release pulses", c, 0);
    endtask

    task automatic t_timed(input logic [1:0] m, input logic [3:0] r,
                           input int p, input string tag);
        int n, at, at2;
        mode = 2'd0;
        repeat (5) @(negedge clk);
        rate = r;
        mode = m;
        n = cyc;
        wait_pulse(p + 10, at);
        chk(at == n + p + 2, "R7", "first pulse after mode change", at - n, p + 2);
        for (int i = 0; i < 3; i++) begin
            wait_pulse(p + 5, at2);
            chk(at2 - at == p, tag, "pulse interval", at2 - at, p);
            at = at2;
        end
    endtask

    task automatic t_slow_to_turbo();
        int n, at, c;
        mode = 2'd1;
        rate = 4'd1;
        repeat (20) @(negedge clk);
        mode = 2'd2;
        n = cyc;
        wait_pulse(TURBO_P + 10, at);
        chk(at == n + TURBO_P + 2, "R7", "slow to turbo first pulse", at - n, TURBO_P + 2);
        c = 0;
    endtask

    task automatic t_ignore();
        int n, c, at;
        // Button in slow mode (R9)
        mode = 2'd0;
        repeat (5) @(negedge clk);
        rate = 4'd1;
        mode = 2'd1;
        n = cyc;
        @(negedge clk);
        btn = 1'b1;
        repeat (12) @(negedge clk);
        btn = 1'b0;
        c = 0;
        wait_pulse(SYS + 10, at);
        chk(at == n + SYS + 2, "R9", "slow pulse with button activity", at - n, SYS + 2);
        // Ticks in step mode (R9)
        mode = 2'd0;
        rate = 4'd15;
        count_pulses(100, c);
        chk(c == 0, "R9", "pulses in step mode without press", c, 0);
    endtask

    task automatic t_halt();
        int c, at;
        mode = 2'd2;
        repeat (20) @(negedge clk);
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        count_pulses(30, c);
        chk(c == 0, "R8", "turbo pulses after halt", c, 0);
        mode = 2'd1;
        rate = 4'd15;
        count_pulses(40, c);
        chk(c == 0, "R8", "slow pulses after halt", c, 0);
        mode = 2'd0;
        repeat (3) @(negedge clk);
        btn = 1'b1;
        count_pulses(20, c);
        btn = 1'b0;
        count_pulses(20, at);
        chk(c + at == 0, "R8", "step pulses after halt", c + at, 0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_step(2'd0, "R3");
        t_step(2'd3, "R2");
        t_glitch();
        t_bounce();
        t_timed(2'd1, 4'd15, SYS / 15, "R4");
        t_timed(2'd1, 4'd7, SYS / 7, "R4");
        t_timed(2'd1, 4'd1, SYS, "R4");
        t_timed(2'd1, 4'd0, SYS, "R5");
        t_timed(2'd2, 4'd3, TURBO_P, "R6");
        t_slow_to_turbo();
        t_ignore();
        t_halt();
        t_step(2'd0, "R8");
        chk(wide_bad == 0, "R10", "back-to-back enables", wide_bad, 0);
        chk(led_bad == 0, "R11", "LED toggle mismatches", led_bad, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule